// File: doc/BRIEF.md
# Motor pulse-width frame receiver

This block listens to one serial motor-control line on which every bit is a pulse whose active width, measured against the bit period, encodes the bit. It times each pulse with the system clock and decides whether the bit is a one or a zero. It collects the bits of a frame and treats a stretch of line silence as the end of that frame. It then splits the 16 bits into an 11-bit value, a telemetry-request flag and a 4-bit checksum, and checks the checksum.

A valid frame raises a one-cycle `frame_valid` strobe. A frame of the right length whose checksum does not match raises a one-cycle `crc_err` strobe instead. The decoded fields stay on `value`, `is_cmd` and `telem` until the next frame of full length arrives.

The bit rate comes from a 2-bit select input. A mode input makes the block accept the inverted line and inverted checksum used on shared bidirectional wiring. Both inputs are sampled only while no frame is in progress.

Top module: `pwm_frame_rx`

## Requirements
- R1: A bit is a one when twice its active time is strictly greater than its period, and a zero otherwise. The period is measured from the bit's start edge to the next bit's start edge. An active time of exactly half the period therefore decodes as zero.
- R2: A frame ends when no edge follows the end of a bit's active phase for three nominal periods. The last bit uses one nominal period as its length. The output strobe appears 3·P+3 clock cycles after the rising clock edge at which the end-of-active level is first present on `line_in`. P is the nominal period in clock cycles.
- R3: Bits are sent most significant first. Frame bits 15..5 appear on `value` (bit 15 is value bit 10), frame bit 4 appears on `telem`, and bits 3..0 are the received checksum.
- R4: In normal mode the expected checksum is bits 15..12 XOR 11..8 XOR 7..4 of the frame. When it equals bits 3..0, `frame_valid` is high for exactly one cycle and `crc_err` stays low.
- R5: With `bidir` = 1, the line is inverted: the idle level is high, a bit starts on a falling edge and ends on a rising edge. The expected checksum is also bitwise inverted.
- R6: A 16-bit frame whose checksum does not match raises `crc_err` for exactly one cycle, leaves `frame_valid` low, and still updates `value`, `is_cmd` and `telem`.
- R7: `is_cmd` is 1 when the decoded value is below 48, and 0 for 48 and above.
- R8: A frame of any length other than 16 bits raises no strobe and leaves `value`, `is_cmd` and `telem` unchanged.
- R9: `rate_sel` values 0, 1, 2 and 3 select the nominal periods `PER_R0`, `PER_R1`, `PER_R2` and `PER_R3` clock cycles. These are the slowest to the fastest rates.
- R10: `rate_sel` and `bidir` are taken only while no frame is in progress. A change during a frame does not alter how that frame is decoded or when it ends.
- R11: While reset is active and just after it, `frame_valid`, `crc_err`, `value`, `is_cmd` and `telem` are all 0.
- R12: `frame_valid` and `crc_err` are never high together, and each is high for at most one cycle in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_in | input | 1 | Serial motor-control line, asynchronous to `clk` |
| rate_sel | input | 2 | Bit-rate select, 0 slowest to 3 fastest |
| bidir | input | 1 | 1 selects inverted line and inverted checksum |
| frame_valid | output | 1 | One-cycle strobe for a 16-bit frame with a good checksum |
| crc_err | output | 1 | One-cycle strobe for a 16-bit frame with a bad checksum |
| value | output | 11 | Decoded value of the most recent 16-bit frame |
| is_cmd | output | 1 | 1 when `value` is below 48 |
| telem | output | 1 | Telemetry-request bit of the most recent 16-bit frame |

## Verification
A bad pulse-width timer shows up at the ports as a flipped bit. That in turn turns an expected `frame_valid` into `crc_err`, or changes `value`, on the frame where the error occurs. A bad silence counter or a stale latched rate moves the strobe away from its exact cycle, 3·P+3 cycles after the last active phase ends. A bit counter that drifts turns a full frame into a dropped one, or a short frame into an output. Each of these shows within one frame, and the bench compares every output on every clock against its own behavioural model.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic [1:0] {
    BT_IDLE = 2'd0,
    BT_HIGH = 2'd1,
    BT_GAP  = 2'd2
  } bt_state_e;

  localparam int FRAME_BITS = 16;
  localparam int VALUE_W    = 11;
  localparam int SUM_W      = 4;
  localparam int CMD_LIMIT  = 48;
  localparam int NUM_RATES  = 4;

  // Fold the 12 payload bits into one nibble.
  function automatic logic [SUM_W-1:0] fold_sum(input logic [11:0] payload);
    return payload[3:0] ^ payload[7:4] ^ payload[11:8];
  endfunction

endpackage

// File: rtl/pfr_edge_sync.sv
module pfr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic inv_mode,
  output logic start_edge,
  output logic stop_edge
);

  logic meta_q, sync_q, last_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  // Raw edges do not depend on the mode, so a mode change never looks like an edge.
  assign rise = sync_q & ~last_q;
  assign fall = ~sync_q & last_q;

  assign start_edge = inv_mode ? fall : rise;
  assign stop_edge  = inv_mode ? rise : fall;

endmodule

// File: rtl/pfr_bit_timer.sv
module pfr_bit_timer
  import pfr_pkg::*;
#(
  parameter int PER_R0 = 1667,
  parameter int PER_R1 = 833,
  parameter int PER_R2 = 417,
  parameter int PER_R3 = 208,
  parameter int CW     = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_edge,
  input  logic       stop_edge,
  input  logic [1:0] rate_q,
  output logic       bit_vld,
  output logic       bit_val,
  output logic       frm_end,
  output logic       idle
);

  localparam int PER_TAB [NUM_RATES] = '{PER_R0, PER_R1, PER_R2, PER_R3};
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] per_sel [NUM_RATES];
  logic [CW-1:0] tmo_sel [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign per_sel[g] = CW'(PER_TAB[g]);
    assign tmo_sel[g] = CW'(3 * PER_TAB[g]);
  end

  bt_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n, quiet_q, quiet_n, hi_q, hi_n;
  logic          bv_n, bval_n, fe_n;
  logic [CW-1:0] cnt_inc, quiet_inc, per, tmo;

  assign per       = per_sel[rate_q];
  assign tmo       = tmo_sel[rate_q];
  assign cnt_inc   = (cnt_q == CMAX) ? cnt_q : cnt_q + CW'(1);
  assign quiet_inc = (quiet_q == CMAX) ? quiet_q : quiet_q + CW'(1);
  assign idle      = (state_q == BT_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_inc;
    quiet_n = quiet_inc;
    hi_n    = hi_q;
    bv_n    = 1'b0;
    bval_n  = 1'b0;
    fe_n    = 1'b0;
    case (state_q)
      BT_IDLE: begin
        if (start_edge) begin
          state_n = BT_HIGH;
          cnt_n   = '0;
          quiet_n = '0;
        end
      end
      BT_HIGH: begin
        if (stop_edge) begin
          state_n = BT_GAP;
          hi_n    = cnt_inc;
          quiet_n = '0;
        end
      end
      BT_GAP: begin
        if (start_edge) begin
          bv_n    = 1'b1;
          bval_n  = {hi_q, 1'b0} > {1'b0, cnt_inc};
          state_n = BT_HIGH;
          cnt_n   = '0;
          quiet_n = '0;
        end else if (quiet_q == tmo - CW'(1)) begin
          bv_n    = 1'b1;
          bval_n  = {hi_q, 1'b0} > {1'b0, per};
          fe_n    = 1'b1;
          state_n = BT_IDLE;
        end
      end
      default: state_n = BT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BT_IDLE;
      cnt_q   <= '0;
      quiet_q <= '0;
      hi_q    <= '0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
      frm_end <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      quiet_q <= quiet_n;
      hi_q    <= hi_n;
      bit_vld <= bv_n;
      bit_val <= bval_n;
      frm_end <= fe_n;
    end
  end

endmodule

// File: rtl/pfr_frame_asm.sv
module pfr_frame_asm
  import pfr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_vld,
  input  logic               bit_val,
  input  logic               frm_end,
  input  logic               inv_mode,
  output logic               frame_valid,
  output logic               crc_err,
  output logic [VALUE_W-1:0] value,
  output logic               is_cmd,
  output logic               telem
);

  localparam int NW = $clog2(FRAME_BITS + 2);
  localparam logic [NW-1:0] NSAT  = NW'(FRAME_BITS + 1);
  localparam logic [NW-1:0] NFULL = NW'(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q, sh_n;
  logic [NW-1:0]         n_q, n_inc, n_n;
  logic                  fv_n, err_n, cmd_n, tel_n;
  logic [VALUE_W-1:0]    val_n;
  logic [SUM_W-1:0]      want;

  assign sh_n  = bit_vld ? {sh_q[FRAME_BITS-2:0], bit_val} : sh_q;
  assign n_inc = (bit_vld && n_q != NSAT) ? n_q + NW'(1) : n_q;
  assign want  = fold_sum(sh_n[FRAME_BITS-1:SUM_W]) ^ {SUM_W{inv_mode}};

  always_comb begin
    n_n   = n_inc;
    fv_n  = 1'b0;
    err_n = 1'b0;
    val_n = value;
    cmd_n = is_cmd;
    tel_n = telem;
    if (frm_end) begin
      n_n = '0;
      if (n_inc == NFULL) begin
        fv_n  = (want == sh_n[SUM_W-1:0]);
        err_n = (want != sh_n[SUM_W-1:0]);
        val_n = sh_n[FRAME_BITS-1:SUM_W+1];
        cmd_n = (sh_n[FRAME_BITS-1:SUM_W+1] < VALUE_W'(CMD_LIMIT));
        tel_n = sh_n[SUM_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q        <= '0;
      n_q         <= '0;
      frame_valid <= 1'b0;
      crc_err     <= 1'b0;
      value       <= '0;
      is_cmd      <= 1'b0;
      telem       <= 1'b0;
    end else begin
      sh_q        <= sh_n;
      n_q         <= n_n;
      frame_valid <= fv_n;
      crc_err     <= err_n;
      value       <= val_n;
      is_cmd      <= cmd_n;
      telem       <= tel_n;
    end
  end

endmodule

// File: rtl/pwm_frame_rx.sv
module pwm_frame_rx
  import pfr_pkg::*;
#(
  parameter int PER_R0 = 1667,
  parameter int PER_R1 = 833,
  parameter int PER_R2 = 417,
  parameter int PER_R3 = 208
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_in,
  input  logic [1:0]         rate_sel,
  input  logic               bidir,
  output logic               frame_valid,
  output logic               crc_err,
  output logic [VALUE_W-1:0] value,
  output logic               is_cmd,
  output logic               telem
);

  localparam int PMAX = (PER_R0 > PER_R1 ? PER_R0 : PER_R1) > (PER_R2 > PER_R3 ? PER_R2 : PER_R3)
                      ? (PER_R0 > PER_R1 ? PER_R0 : PER_R1) : (PER_R2 > PER_R3 ? PER_R2 : PER_R3);
  localparam int CW = $clog2(4 * PMAX + 2);

  logic       rs_a, rs_b;
  logic       mode_q;
  logic [1:0] rate_q;
  logic       start_edge, stop_edge;
  logic       bit_vld, bit_val, frm_end, idle;

  // Reset: asserted at once, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  // Mode and rate are taken only between frames.
  always_ff @(posedge clk or negedge rs_b) begin
    if (!rs_b) begin
      mode_q <= 1'b0;
      rate_q <= 2'd0;
    end else if (idle) begin
      mode_q <= bidir;
      rate_q <= rate_sel;
    end
  end

  pfr_edge_sync u_sync (
    .clk        (clk),
    .rst_n      (rs_b),
    .din        (line_in),
    .inv_mode   (mode_q),
    .start_edge (start_edge),
    .stop_edge  (stop_edge)
  );

  pfr_bit_timer #(
    .PER_R0 (PER_R0),
    .PER_R1 (PER_R1),
    .PER_R2 (PER_R2),
    .PER_R3 (PER_R3),
    .CW     (CW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rs_b),
    .start_edge (start_edge),
    .stop_edge  (stop_edge),
    .rate_q     (rate_q),
    .bit_vld    (bit_vld),
    .bit_val    (bit_val),
    .frm_end    (frm_end),
    .idle       (idle)
  );

  pfr_frame_asm u_asm (
    .clk         (clk),
    .rst_n       (rs_b),
    .bit_vld     (bit_vld),
    .bit_val     (bit_val),
    .frm_end     (frm_end),
    .inv_mode    (mode_q),
    .frame_valid (frame_valid),
    .crc_err     (crc_err),
    .value       (value),
    .is_cmd      (is_cmd),
    .telem       (telem)
  );

endmodule

// File: rtl/pwm_frame_rx_chk.sv
module pwm_frame_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic        crc_err,
  input logic [10:0] value,
  input logic        is_cmd,
  input logic        telem
);

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && crc_err));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err);

  assert_hold_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && !crc_err) |-> ($stable(value) && $stable(telem) && $stable(is_cmd)));

  assert_cmd_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || crc_err) |-> (is_cmd == (value < 11'd48)));

endmodule

bind pwm_frame_rx pwm_frame_rx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .crc_err     (crc_err),
  .value       (value),
  .is_cmd      (is_cmd),
  .telem       (telem)
);

// File: tb/sim_pwm_frame_rx.sv
`timescale 1ns/1ps
module sim_pwm_frame_rx;

  localparam int P0 = 40, P1 = 20, P2 = 12, P3 = 8;
  localparam int TAIL = 3 * P0 + 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_in;
  logic [1:0]  rate_sel;
  logic        bidir;
  logic        frame_valid, crc_err, is_cmd, telem;
  logic [10:0] value;

  always #2 clk = ~clk;

  pwm_frame_rx #(.PER_R0(P0), .PER_R1(P1), .PER_R2(P2), .PER_R3(P3)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rate_sel(rate_sel), .bidir(bidir),
    .frame_valid(frame_valid), .crc_err(crc_err), .value(value), .is_cmd(is_cmd), .telem(telem)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int per_of(input logic [1:0] r);
    case (r)
      2'd0: return P0;
      2'd1: return P1;
      2'd2: return P2;
      default: return P3;
    endcase
  endfunction

  function automatic logic [3:0] sum_of(input logic [15:0] w, input logic inv);
    logic [3:0] s = 4'h0;
    for (int k = 1; k < 4; k++) s = s ^ w[4*k +: 4];
    return inv ? ~s : s;
  endfunction

  function automatic logic [15:0] mk(input int v, input bit t, input bit inv);
    logic [15:0] w;
    w = {v[10:0], t, 4'h0};
    w[3:0] = sum_of(w, inv);
    return w;
  endfunction

  // Behavioural reference model, one step per clock
  int          cyc, m_st, tS, tF, m_per, m_nb, pend_t;
  bit          m_mode, prev, pend;
  logic [31:0] m_acc;
  bit          e_fv, e_err, e_cmd, e_tel, p_fv, p_err, p_cmd, p_tel;
  int          e_val, p_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_st = 0; pend = 0; prev = line_in;
      e_fv = 0; e_err = 0; e_val = 0; e_cmd = 0; e_tel = 0;
      m_mode = bidir; m_per = per_of(rate_sel);
    end else begin
      bit v, st_e, en_e, b;
      cyc++;
      e_fv = 0; e_err = 0;
      if (pend && cyc == pend_t) begin
        e_fv = p_fv; e_err = p_err; e_val = p_val; e_cmd = p_cmd; e_tel = p_tel; pend = 0;
      end
      v = line_in;
      st_e = m_mode ? (prev && !v) : (!prev && v);
      en_e = m_mode ? (!prev && v) : (prev && !v);
      case (m_st)
        0: begin
          m_mode = bidir; m_per = per_of(rate_sel);
          st_e = m_mode ? (prev && !v) : (!prev && v);
          if (st_e) begin tS = cyc; m_st = 1; m_nb = 0; m_acc = 0; end
        end
        1: if (en_e) begin tF = cyc; m_st = 2; end
        default: begin
          if (st_e) begin
            b = 2 * (tF - tS) > (cyc - tS);
            m_acc = {m_acc[30:0], b}; m_nb++;
            tS = cyc; m_st = 1;
          end else if (cyc - tF == 3 * m_per) begin
            b = 2 * (tF - tS) > m_per;
            m_acc = {m_acc[30:0], b}; m_nb++;
            m_st = 0;
            if (m_nb == 16) begin
              pend = 1; pend_t = cyc + 3;
              p_fv = (sum_of(m_acc[15:0], m_mode) == m_acc[3:0]);
              p_err = !p_fv;
              p_val = int'(m_acc[15:5]);
              p_cmd = p_val < 48;
              p_tel = m_acc[4];
            end
          end
        end
      endcase
      prev = v;
    end
  end

  int got_fv, got_err;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      got_fv += int'(frame_valid);
      got_err += int'(crc_err);
      chk(frame_valid === e_fv, "R2,R4 frame_valid timing", frame_valid, e_fv);
      chk(crc_err === e_err, "R6 crc_err timing", crc_err, e_err);
      chk(int'(value) == e_val, "R3 value", value, e_val);
      chk(is_cmd === e_cmd, "R7 is_cmd", is_cmd, e_cmd);
      chk(telem === e_tel, "R3 telem", telem, e_tel);
    end
  end

  task automatic send(input logic [31:0] bits, input int nb, input int h0, input int h1,
                      input int chg_at, input logic [1:0] chg_rate);
    int P;
    P = per_of(rate_sel);
    for (int i = nb - 1; i >= 0; i--) begin
      int h;
      if (nb - 1 - i == chg_at) rate_sel = chg_rate;
      h = bits[i] ? h1 : h0;
      line_in = ~bidir;
      repeat (h) @(negedge clk);
      line_in = bidir;
      repeat (P - h) @(negedge clk);
    end
    repeat (TAIL) @(negedge clk);
  endtask

  // Sends a frame with nominal duty and checks the strobes against the expected outcome.
  task automatic frame(input logic [31:0] bits, input int nb, input string rq, input int vdef);
    int P, xv;
    bit good;
    P = per_of(rate_sel);
    got_fv = 0; got_err = 0;
    send(bits, nb, P / 3, (2 * P + 2) / 3, -1, 2'd0);
    if (nb == 16) begin
      good = sum_of(bits[15:0], bidir) == bits[3:0];
      xv = int'(bits[15:5]);
    end else begin
      good = 0; xv = vdef;
    end
    chk(got_fv == ((nb == 16 && good) ? 1 : 0), rq, got_fv, (nb == 16 && good) ? 1 : 0);
    chk(got_err == ((nb == 16 && !good) ? 1 : 0), rq, got_err, (nb == 16 && !good) ? 1 : 0);
    chk(int'(value) == xv, rq, value, xv);
  endtask

  initial begin
    rst_n = 0; line_in = 0; rate_sel = 2'd3; bidir = 0;
    repeat (5) @(negedge clk);
    chk(frame_valid === 0 && crc_err === 0, "R11 strobes in reset", frame_valid | crc_err, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(value == 0 && is_cmd == 0 && telem == 0, "R11 fields after reset", value, 0);

    // R9: every rate, throttle values
    rate_sel = 2'd3; frame({16'h0, mk(1000, 0, 0)}, 16, "R9 rate3 / R3 R4", 0);
    rate_sel = 2'd2; frame({16'h0, mk(1234, 1, 0)}, 16, "R9 rate2 / R3", 0);
    rate_sel = 2'd1; frame({16'h0, mk(2047, 1, 0)}, 16, "R9 rate1 max value", 0);
    rate_sel = 2'd0; frame({16'h0, mk(5, 0, 0)}, 16, "R9 rate0 / R7 command", 0);
    rate_sel = 2'd3;
    // R7 boundary
    frame({16'h0, mk(47, 1, 0)}, 16, "R7 value 47 is command", 0);
    chk(is_cmd === 1, "R7 47", is_cmd, 1);
    frame({16'h0, mk(48, 0, 0)}, 16, "R7 value 48 is throttle", 0);
    chk(is_cmd === 0, "R7 48", is_cmd, 0);
    // R6 bad checksum
    frame({16'h0, mk(700, 1, 0) ^ 16'h0001}, 16, "R6 bad checksum", 0);
    chk(value == 700 && telem == 1, "R6 fields still updated", value, 700);
    // R8 short and long frames
    frame({17'h0, mk(300, 0, 0) >> 1}, 15, "R8 fifteen bits", 700);
    frame({15'h0, mk(301, 0, 0), 1'b1}, 17, "R8 seventeen bits", 700);
    // R1 half duty is zero, half plus one is one
    rate_sel = 2'd2;
    got_fv = 0; got_err = 0;
    send({16'h0, mk(1365, 1, 0)}, 16, P2 / 2, P2 / 2 + 1, -1, 2'd0);
    chk(got_fv == 1 && value == 1365, "R1 half-period duty", value, 1365);
    // R10 rate change mid-frame is ignored
    rate_sel = 2'd3;
    got_fv = 0;
    send({16'h0, mk(999, 0, 0)}, 16, P3 / 3, (2 * P3 + 2) / 3, 5, 2'd0);
    chk(got_fv == 1 && value == 999, "R10 mid-frame rate change", value, 999);
    rate_sel = 2'd3;
    repeat (10) @(negedge clk);
    // R5 bidirectional mode
    bidir = 1; line_in = 1;
    repeat (20) @(negedge clk);
    frame({16'h0, mk(1500, 1, 1)}, 16, "R5 inverted line and checksum", 0);
    frame({16'h0, mk(1501, 0, 0)}, 16, "R5 plain checksum rejected", 0);
    chk(got_err == 1, "R5 R6 bidir mismatch", got_err, 1);
    rate_sel = 2'd1;
    frame({16'h0, mk(12, 0, 1)}, 16, "R5 R7 bidir command", 0);
    bidir = 0; line_in = 0;
    repeat (20) @(negedge clk);
    frame({16'h0, mk(2000, 0, 0)}, 16, "R5 back to normal", 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule